// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps the character codes for a multiplexed display of up to sixteen digits and replays them to the display one digit at a time. The digit index advances on a fixed prescaled interval. For each digit the stored byte is split across two 4-bit output ports, and a blanking strobe hides the moment at which the digit select changes. A mode input picks a 4, 8 or 16 digit display, and the refresh cycles through only that many locations.

A host loads the storage through a small command interface. It can set the address, which also latches whether auto-increment is on, write a data byte, or read a byte back. In left-entry mode a write lands at the current address. In right-entry mode every write pushes the existing characters one place toward location 0 and puts the new byte in the highest active location, like a calculator display filling from the right.

Each port can be blanked, which forces it to a host-supplied blank code, or inhibited, which freezes it at its last value. Segment decoding and the digit drivers sit outside the block.

Top module: `disp_refresh`

## Requirements
- R1: After synchronous reset: `digit_o` = 0, `port_a` = `port_b` = 0, `disp_blank` = 1, every storage location holds 0, the address is 0 and auto-increment is off.
- R2: Only one host command is taken per cycle, with priority `addr_set` > `wr_en` > `rd_en`. In left-entry mode (`right_entry` = 0) a write stores `wr_data` at the current address. A read presents the byte at the current address on `rd_data` one cycle after `rd_en`.
- R3: `addr_set` loads the address and latches `ai_en`. With auto-increment latched, the address advances by one after each accepted read and each left-entry write. Without it, the address does not move.
- R4: The active digit count is 4 for `size_sel` = 0, 8 for 1, and 16 for 2 or 3. `addr_val` is taken modulo that count, and an advancing address wraps from the last active location to 0.
- R5: In right-entry mode a write moves each active location k+1 into location k and stores the new byte in the last active location. The write leaves the address unchanged.
- R6: A right-entry write leaves locations at or above the active count unchanged. On a 16-digit display the seventeenth entry pushes the first one out.
- R7: `digit_o` advances every SCAN_DIV cycles through 0 .. count-1 and then back to 0.
- R8: `port_a` shows bits 7:4 and `port_b` bits 3:0 of the location named by `digit_o`, in the same cycle as `digit_o`.
- R9: While `blank_a` (`blank_b`) is high, `port_a` (`port_b`) shows `blank_code[7:4]` (`blank_code[3:0]`) from the next cycle on.
- R10: While `inhibit_a` (`inhibit_b`) is high and the same port is not blanked, that port holds its value. Blanking overrides inhibit.
- R11: `disp_blank` is high in the cycle before each `digit_o` change and for BLANK_CYC cycles starting with the change. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write a data byte |
| wr_data | input | CHAR_W | Byte to write |
| addr_set | input | 1 | Load address and auto-increment flag |
| addr_val | input | log2(DEPTH) | Address to load |
| ai_en | input | 1 | Auto-increment flag loaded with the address |
| rd_en | input | 1 | Read the byte at the address |
| rd_data | output | CHAR_W | Read result, one cycle after rd_en |
| right_entry | input | 1 | 1 = right-entry writes, 0 = addressed writes |
| size_sel | input | 2 | Display size: 0 = 4, 1 = 8, 2/3 = 16 digits |
| blank_a | input | 1 | Force port A to the blank code |
| blank_b | input | 1 | Force port B to the blank code |
| inhibit_a | input | 1 | Freeze port A |
| inhibit_b | input | 1 | Freeze port B |
| blank_code | input | CHAR_W | Blank pattern, upper half to A, lower half to B |
| digit_o | output | log2(DEPTH) | Current digit select |
| port_a | output | CHAR_W/2 | Upper nibble of the current digit |
| port_b | output | CHAR_W/2 | Lower nibble of the current digit |
| disp_blank | output | 1 | Blanking strobe around digit changes |

## Verification
Corrupted storage or a wrong shift shows up on `rd_data` one cycle after the read that reaches the bad location. It also shows on the nibble ports within one full refresh pass, which is at most 16 × SCAN_DIV cycles. A wrong address step or wrap makes a read return a neighbouring location's byte, so the bench walks the address across every wrap boundary. A scan counter or blank-strobe fault appears at the very next digit change, when the bench compares the new digit with its predecessor, the interval with SCAN_DIV, and the width of the strobe with BLANK_CYC + 1.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    SZ_FOUR    = 2'd0,
    SZ_EIGHT   = 2'd1,
    SZ_SIXTEEN = 2'd2,
    SZ_FULL    = 2'd3
  } size_e;

  function automatic int unsigned digit_count(input size_e sz);
    case (sz)
      SZ_FOUR:  return 4;
      SZ_EIGHT: return 8;
      default:  return 16;
    endcase
  endfunction
endpackage

// File: rtl/disp_addr.sv
module disp_addr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic [AW-1:0] set_val,
  input  logic          set_ai,
  input  logic          step,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] addr_q,
  output logic          ai_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ai_q   <= 1'b0;
    end else if (set) begin
      addr_q <= set_val & last;
      ai_q   <= set_ai;
    end else if (step && ai_q) begin
      addr_q <= (addr_q >= last) ? '0 : addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/disp_store.sv
module disp_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          right,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] last,
  input  logic          rd,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] scan_addr,
  output logic [W-1:0]  host_q,
  output logic [W-1:0]  scan_data
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] nxt [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    localparam logic [AW-1:0] IDX = AW'(i);
    logic [W-1:0] upper;
    if (i < DEPTH - 1) begin : g_mid
      assign upper = mem[i+1];
    end else begin : g_top
      assign upper = mem[i];
    end
    always_comb begin
      nxt[i] = mem[i];
      if (wr) begin
        if (right) begin
          if (IDX == last)     nxt[i] = wr_data;
          else if (IDX < last) nxt[i] = upper;
        end else if (wr_addr == IDX) begin
          nxt[i] = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (rst) mem[k] <= '0;
      else     mem[k] <= nxt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     host_q <= '0;
    else if (rd) host_q <= mem[rd_addr];
  end

  assign scan_data = mem[scan_addr];
endmodule

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int SCAN_DIV  = 64,
  parameter int BLANK_CYC = 4,
  parameter int AW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] digit_q,
  output logic          blank_raw
);
  localparam int CW = $clog2(SCAN_DIV);
  localparam logic [CW-1:0] CNT_END = CW'(SCAN_DIV - 1);
  localparam logic [CW-1:0] CNT_BLK = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      digit_q <= '0;
    end else if (cnt_q == CNT_END) begin
      cnt_q   <= '0;
      digit_q <= (digit_q >= last) ? '0 : digit_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign blank_raw = (cnt_q < CNT_BLK) || (cnt_q == CNT_END);
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh #(
  parameter int DEPTH     = 16,
  parameter int CHAR_W    = 8,
  parameter int SCAN_DIV  = 64,
  parameter int BLANK_CYC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [CHAR_W-1:0]          wr_data,
  input  logic                       addr_set,
  input  logic [$clog2(DEPTH)-1:0]   addr_val,
  input  logic                       ai_en,
  input  logic                       rd_en,
  output logic [CHAR_W-1:0]          rd_data,
  input  logic                       right_entry,
  input  logic [1:0]                 size_sel,
  input  logic                       blank_a,
  input  logic                       blank_b,
  input  logic                       inhibit_a,
  input  logic                       inhibit_b,
  input  logic [CHAR_W-1:0]          blank_code,
  output logic [$clog2(DEPTH)-1:0]   digit_o,
  output logic [CHAR_W/2-1:0]        port_a,
  output logic [CHAR_W/2-1:0]        port_b,
  output logic                       disp_blank
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = CHAR_W / 2;

  logic [AW-1:0]     last;
  logic [AW-1:0]     addr_q;
  logic              ai_q;
  logic [AW-1:0]     digit_q;
  logic              blank_raw;
  logic [CHAR_W-1:0] scan_data;
  logic              do_wr, do_rd, step;
  int unsigned       n_dig;

  always_comb begin
    n_dig = disp_pkg::digit_count(disp_pkg::size_e'(size_sel));
    if (n_dig > DEPTH) n_dig = DEPTH;
    last = AW'(n_dig - 1);
  end

  assign do_wr = wr_en && !addr_set;
  assign do_rd = rd_en && !addr_set && !wr_en;
  assign step  = (do_wr && !right_entry) || do_rd;

  disp_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .set(addr_set), .set_val(addr_val),
    .set_ai(ai_en), .step(step), .last(last),
    .addr_q(addr_q), .ai_q(ai_q)
  );

  disp_store #(.DEPTH(DEPTH), .W(CHAR_W), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .wr(do_wr), .right(right_entry),
    .wr_addr(addr_q), .wr_data(wr_data), .last(last),
    .rd(do_rd), .rd_addr(addr_q), .scan_addr(digit_q),
    .host_q(rd_data), .scan_data(scan_data)
  );

  disp_scan #(.SCAN_DIV(SCAN_DIV), .BLANK_CYC(BLANK_CYC), .AW(AW)) u_scan (
    .clk(clk), .rst(rst), .last(last),
    .digit_q(digit_q), .blank_raw(blank_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_o    <= '0;
      disp_blank <= 1'b1;
      port_a     <= '0;
      port_b     <= '0;
    end else begin
      digit_o    <= digit_q;
      disp_blank <= blank_raw;
      if (blank_a)         port_a <= blank_code[CHAR_W-1:HALF];
      else if (!inhibit_a) port_a <= scan_data[CHAR_W-1:HALF];
      if (blank_b)         port_b <= blank_code[HALF-1:0];
      else if (!inhibit_b) port_b <= scan_data[HALF-1:0];
    end
  end
endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk #(
  parameter int AW     = 4,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     digit_o,
  input logic [CHAR_W/2-1:0] port_a,
  input logic [CHAR_W/2-1:0] port_b,
  input logic              disp_blank,
  input logic              blank_a,
  input logic              blank_b,
  input logic              inhibit_a,
  input logic              inhibit_b,
  input logic [CHAR_W-1:0] blank_code,
  input logic              rd_en,
  input logic              wr_en,
  input logic              addr_set,
  input logic              right_entry,
  input logic [AW-1:0]     addr_q,
  input logic              ai_q
);
  localparam int HALF = CHAR_W / 2;

  assert_blank_switch_R11: assert property (@(posedge clk) disable iff (rst)
    (digit_o != $past(digit_o)) |-> (disp_blank && $past(disp_blank)));

  assert_digit_step_R7: assert property (@(posedge clk) disable iff (rst)
    (digit_o != $past(digit_o)) |-> (digit_o == '0 || digit_o == $past(digit_o) + 1'b1));

  assert_blank_a_R9: assert property (@(posedge clk) disable iff (rst)
    blank_a |=> (port_a == $past(blank_code[CHAR_W-1:HALF])));

  assert_blank_b_R9: assert property (@(posedge clk) disable iff (rst)
    blank_b |=> (port_b == $past(blank_code[HALF-1:0])));

  assert_inhibit_a_R10: assert property (@(posedge clk) disable iff (rst)
    (inhibit_a && !blank_a) |=> $stable(port_a));

  assert_inhibit_b_R10: assert property (@(posedge clk) disable iff (rst)
    (inhibit_b && !blank_b) |=> $stable(port_b));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !addr_set && !ai_q) |=> (addr_q == $past(addr_q)));

  assert_right_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && right_entry && !addr_set) |=> (addr_q == $past(addr_q)));
endmodule

bind disp_refresh disp_refresh_chk #(.AW($clog2(DEPTH)), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .digit_o(digit_o), .port_a(port_a), .port_b(port_b),
  .disp_blank(disp_blank), .blank_a(blank_a), .blank_b(blank_b),
  .inhibit_a(inhibit_a), .inhibit_b(inhibit_b), .blank_code(blank_code),
  .rd_en(rd_en), .wr_en(wr_en), .addr_set(addr_set), .right_entry(right_entry),
  .addr_q(addr_q), .ai_q(ai_q)
);

// File: tb/sim_disp_refresh.sv
`timescale 1ns/1ps
module sim_disp_refresh;
  localparam int SD = 8;
  localparam int BC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       wr_en = 0, addr_set = 0, ai_en = 0, rd_en = 0, right_entry = 0;
  logic [7:0] wr_data = 0, blank_code = 8'h5A;
  logic [3:0] addr_val = 0;
  logic [1:0] size_sel = 2'd2;
  logic       blank_a = 0, blank_b = 0, inhibit_a = 0, inhibit_b = 0;
  logic [7:0] rd_data;
  logic [3:0] digit_o, port_a, port_b;
  logic       disp_blank;

  disp_refresh #(.DEPTH(16), .CHAR_W(8), .SCAN_DIV(SD), .BLANK_CYC(BC)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .addr_set(addr_set),
    .addr_val(addr_val), .ai_en(ai_en), .rd_en(rd_en), .rd_data(rd_data),
    .right_entry(right_entry), .size_sel(size_sel), .blank_a(blank_a),
    .blank_b(blank_b), .inhibit_a(inhibit_a), .inhibit_b(inhibit_b),
    .blank_code(blank_code), .digit_o(digit_o), .port_a(port_a),
    .port_b(port_b), .disp_blank(disp_blank)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [16];
  int   exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for host reads
  logic rd_seen = 0;
  always @(posedge clk) rd_seen <= rd_en && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected read", rd_data, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e[7:0], t, rd_data, e);
      end
    end
  end

  task automatic set_addr(input int a, input bit ai);
    @(negedge clk); addr_set = 1; addr_val = a[3:0]; ai_en = ai;
    @(negedge clk); addr_set = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1; exp_q.push_back(int'(e)); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  function automatic int ndig(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
  endfunction

  task automatic right_push(input logic [7:0] d);
    int n;
    n = ndig(size_sel);
    for (int k = 0; k < n - 1; k++) model[k] = model[k+1];
    model[n-1] = d;
    wr(d);
  endtask

  // mode: 0 normal, 1 blank A, 2 inhibit B, 3 blank+inhibit B
  task automatic observe(input int ncyc, input int mode);
    int n, since, pd;
    bit pb, seen;
    logic [3:0] hold_b;
    n = ndig(size_sel);
    repeat (2 * SD) @(negedge clk);
    pd = digit_o; pb = disp_blank; seen = 0; since = 0; hold_b = port_b;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      since++;
      check(digit_o < n, "R7 digit in range", digit_o, n - 1);
      if (digit_o != pd[3:0]) begin
        check(digit_o == (pd + 1) % n, "R7 digit order", digit_o, (pd + 1) % n);
        check(disp_blank && pb, "R11 blank at switch", {pb, disp_blank}, 3);
        if (seen) check(since == SD, "R7 digit period", since, SD);
        seen = 1; since = 0;
      end else if (seen) begin
        check(disp_blank == (since < BC || since == SD - 1), "R11 blank window",
              disp_blank, (since < BC || since == SD - 1));
      end
      if (mode == 1) check(port_a == blank_code[7:4], "R9 port A blank", port_a, blank_code[7:4]);
      else check(port_a == model[digit_o][7:4], "R8 port A data", port_a, model[digit_o][7:4]);
      if (mode == 2) check(port_b == hold_b, "R10 port B inhibited", port_b, hold_b);
      else if (mode == 3) check(port_b == blank_code[3:0], "R10 blank over inhibit", port_b, blank_code[3:0]);
      else check(port_b == model[digit_o][3:0], "R8 port B data", port_b, model[digit_o][3:0]);
      pd = digit_o; pb = disp_blank;
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) model[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(digit_o == 0, "R1 reset digit", digit_o, 0);
    check(port_a == 0 && port_b == 0, "R1 reset ports", {port_a, port_b}, 0);
    check(disp_blank == 1, "R1 reset blank", disp_blank, 1);
    // R1: storage zero, address 0, AI off -> both reads hit location 0
    rd(8'h00, "R1 reset storage");
    rd(8'h00, "R1 reset address");

    // R2 R3 R4: left entry, 16 digits, auto-increment and wrap
    set_addr(0, 1);
    for (int k = 0; k < 16; k++) begin
      model[k] = 8'(k * 8'h11 + 1);
      wr(model[k]);
    end
    model[0] = 8'hEE;
    wr(8'hEE);
    set_addr(0, 1);
    for (int k = 0; k < 16; k++) rd(model[k], "R2 R4 left entry readback");

    // R3: auto-increment off keeps address
    set_addr(5, 0);
    wr(8'h55);
    wr(8'h66);
    model[5] = 8'h66;
    rd(8'h66, "R3 hold address write");
    rd(8'h66, "R3 hold address read");
    set_addr(6, 1);
    rd(model[6], "R3 neighbour untouched");

    // R4: 4-digit size, address masked and wraps at 3
    size_sel = 2'd0;
    set_addr(7, 1);
    wr(8'h33); model[3] = 8'h33;
    wr(8'h44); model[0] = 8'h44;
    set_addr(0, 1);
    rd(model[0], "R4 wrap loc0");
    rd(model[1], "R4 wrap loc1");
    rd(model[2], "R4 wrap loc2");
    rd(model[3], "R4 wrap loc3");
    rd(model[0], "R4 read wraps to 0");

    observe(5 * 4 * SD, 0);
    size_sel = 2'd2;
    observe(2 * 16 * SD, 0);

    // R5 R6: right entry on 8 digits, address stays, upper half untouched
    right_entry = 1;
    size_sel = 2'd1;
    set_addr(2, 1);
    for (int k = 0; k < 9; k++) right_push(8'hC0 + 8'(k));
    right_entry = 0;
    for (int k = 0; k < 8; k++) rd(model[(k + 2) % 8], "R5 shifted content, address unchanged");
    size_sel = 2'd2;
    set_addr(8, 1);
    for (int k = 8; k < 16; k++) rd(model[k], "R6 upper locations untouched");

    // R6: 17 right-entry writes on 16 digits
    right_entry = 1;
    for (int k = 0; k < 17; k++) right_push(8'h20 + 8'(k * 3));
    right_entry = 0;
    set_addr(0, 1);
    for (int k = 0; k < 16; k++) rd(model[k], "R6 seventeenth entry drops first");
    check(model[0] == 8'h23, "R6 model sanity", model[0], 8'h23);

    observe(16 * SD, 0);
    @(negedge clk); blank_a = 1;
    observe(3 * SD, 1);
    @(negedge clk); blank_a = 0; inhibit_b = 1;
    observe(3 * SD, 2);
    @(negedge clk); blank_b = 1; blank_code = 8'hA7;
    observe(3 * SD, 3);
    @(negedge clk); blank_b = 0; inhibit_b = 0;
    observe(2 * 16 * SD, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule